// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers and turns a segment and a 16-bit offset into a 20-bit physical memory address. The four registers are named extra, code, stack and data. The address is the segment value shifted left by four bits plus the offset. As a result, each segment reaches a 64 KB window, and those windows overlap inside a 1 MB space. Any sum that runs past 1 MB wraps back to the bottom of the space.

A register write port loads any of the segment registers. A request port picks a segment and supplies an offset. A separate fetch port always pairs the code segment with an instruction-pointer offset, and it takes precedence over the request port. The resulting address comes out of a register one cycle after the request, together with a valid strobe. When no request is made, the last address stays on the output.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, addr_valid_o is 0 and addr_o is 0. The extra, stack and data segments reset to 0000h and the code segment resets to FFFFh.
- R2: A request in cycle N yields addr_o = (segment << 4) + offset in cycle N+1. For example, data segment 2000h with offset 0050h gives 20050h.
- R3: A carry out of bit 19 is discarded, so the address wraps modulo 2^20. For example, FFFFh:0010h gives 00000h.
- R4: The segment select encoding, on both seg_sel_i and seg_wsel_i, is 0 = extra, 1 = code, 2 = stack, 3 = data.
- R5: A segment write takes effect from the next cycle. A request in the same cycle as a write to the same register uses the old value.
- R6: When fetch_i is high, the address uses the code segment with ip_i as the offset, whatever req_i, seg_sel_i and offset_i are.
- R7: addr_valid_o equals (req_i | fetch_i) of the previous cycle.
- R8: In a cycle after one with neither req_i nor fetch_i, addr_o holds its previous value.
- R9: With seg_we_i low, seg_wsel_i and seg_wdata_i change no segment register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write enable |
| seg_wsel_i | input | 2 | Segment register to write |
| seg_wdata_i | input | 16 | Value to write |
| req_i | input | 1 | Address request |
| seg_sel_i | input | 2 | Segment used by the request |
| offset_i | input | 16 | Offset used by the request |
| fetch_i | input | 1 | Fetch request (code segment plus ip_i) |
| ip_i | input | 16 | Instruction pointer offset |
| addr_o | output | 20 | Registered physical address |
| addr_valid_o | output | 1 | addr_o was produced by the previous cycle's request |

## Verification
A corrupted segment register cannot be seen on its own. It shows up only when a request or fetch next selects that register, and then addr_o differs from the reference one cycle later. A write that lands a cycle early or late, or in the wrong slot, becomes visible on the first access that follows. Wrong wrap or shift arithmetic is visible as soon as an offending segment and offset pair is issued. Directed cases target the reset code segment, the wrap at 1 MB and a write issued together with a request to the same register.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned NUM_SEG = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_sel_e;

  function automatic logic [31:0] seg_reset_val(input int unsigned idx, input logic [31:0] code_rst);
    return (idx == int'(SEG_CODE)) ? code_rst : 32'd0;
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int unsigned SEG_W    = 16,
  parameter logic [31:0] CODE_RST = 32'h0000_FFFF
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [seg_addr_pkg::SEL_W-1:0]      wsel_i,
  input  logic [SEG_W-1:0]                    wdata_i,
  input  logic [seg_addr_pkg::SEL_W-1:0]      rsel_i,
  output logic [SEG_W-1:0]                    rdata_o,
  output logic [SEG_W-1:0]                    code_o
);
  import seg_addr_pkg::*;

  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [31:0] RST_FULL = seg_reset_val(g, CODE_RST);
    localparam logic [SEG_W-1:0] RST_V = RST_FULL[SEG_W-1:0];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seg_q[g] <= RST_V;
      end else if (we_i && (wsel_i == SEL_W'(g))) begin
        seg_q[g] <= wdata_i;
      end
    end
  end

  // reads see pre-write contents
  assign rdata_o = seg_q[rsel_i];
  assign code_o  = seg_q[SEG_CODE];
endmodule

// File: rtl/seg_pa_adder.sv
module seg_pa_adder #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SEG_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  assign base    = {seg_i, {SHIFT{1'b0}}};
  assign off_ext = ADDR_W'(off_i);
  // carry out of the top bit is dropped
  assign addr_o  = base + off_ext;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned SHIFT    = 4,
  parameter logic [31:0] CODE_RST = 32'h0000_FFFF,
  localparam int unsigned ADDR_W  = SEG_W + SHIFT
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               seg_we_i,
  input  logic [seg_addr_pkg::SEL_W-1:0]     seg_wsel_i,
  input  logic [SEG_W-1:0]                   seg_wdata_i,
  input  logic                               req_i,
  input  logic [seg_addr_pkg::SEL_W-1:0]     seg_sel_i,
  input  logic [SEG_W-1:0]                   offset_i,
  input  logic                               fetch_i,
  input  logic [SEG_W-1:0]                   ip_i,
  output logic [ADDR_W-1:0]                  addr_o,
  output logic                               addr_valid_o
);
  logic [SEG_W-1:0]  sel_seg, code_seg, use_seg, use_off;
  logic [ADDR_W-1:0] pa_d, addr_q;
  logic              valid_q, take;

  seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (seg_we_i),
    .wsel_i  (seg_wsel_i),
    .wdata_i (seg_wdata_i),
    .rsel_i  (seg_sel_i),
    .rdata_o (sel_seg),
    .code_o  (code_seg)
  );

  // fetch path has priority over the generic request
  always_comb begin
    use_seg = fetch_i ? code_seg : sel_seg;
    use_off = fetch_i ? ip_i     : offset_i;
  end

  seg_pa_adder #(.SEG_W(SEG_W), .SHIFT(SHIFT)) u_add (
    .seg_i  (use_seg),
    .off_i  (use_off),
    .addr_o (pa_d)
  );

  assign take = req_i | fetch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) addr_q <= pa_d;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned SHIFT    = 4,
  parameter logic [31:0] CODE_RST = 32'h0000_FFFF,
  localparam int unsigned ADDR_W  = SEG_W + SHIFT
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           seg_we_i,
  input logic [seg_addr_pkg::SEL_W-1:0] seg_wsel_i,
  input logic [SEG_W-1:0]               seg_wdata_i,
  input logic                           req_i,
  input logic [seg_addr_pkg::SEL_W-1:0] seg_sel_i,
  input logic [SEG_W-1:0]               offset_i,
  input logic                           fetch_i,
  input logic [SEG_W-1:0]               ip_i,
  input logic [ADDR_W-1:0]              addr_o,
  input logic                           addr_valid_o
);
  logic [SEG_W-1:0]  sh_seg [4];
  logic [ADDR_W-1:0] exp_q;
  logic              armed_q;
  logic [SEG_W-1:0]  s_pick, o_pick;

  always_comb begin
    s_pick = fetch_i ? sh_seg[1] : sh_seg[seg_sel_i];
    o_pick = fetch_i ? ip_i : offset_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_seg[0] <= '0;
      sh_seg[1] <= CODE_RST[SEG_W-1:0];
      sh_seg[2] <= '0;
      sh_seg[3] <= '0;
      exp_q     <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (seg_we_i) sh_seg[seg_wsel_i] <= seg_wdata_i;
      if (req_i || fetch_i)
        exp_q <= ADDR_W'({s_pick, {SHIFT{1'b0}}}) + ADDR_W'(o_pick);
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_out_chk: assert (!addr_valid_o && addr_o == '0);
  end

  // R7
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (addr_valid_o == $past(req_i | fetch_i)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !req_i && !fetch_i) |=> $stable(addr_o));

  // R2
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> (addr_o == exp_q));

  // R6
  fetch_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> (addr_o == ADDR_W'({$past(sh_seg[1]), {SHIFT{1'b0}}}) + ADDR_W'($past(ip_i))));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .SHIFT(SHIFT), .CODE_RST(CODE_RST)) u_chk (.*);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  localparam int SEG_W = 16;
  localparam int ADDR_W = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic seg_we_i = 0, req_i = 0, fetch_i = 0;
  logic [1:0] seg_wsel_i = 0, seg_sel_i = 0;
  logic [15:0] seg_wdata_i = 0, offset_i = 0, ip_i = 0;
  logic [19:0] addr_o;
  logic addr_valid_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] model [4];
  logic [19:0] exp_addr = 0;
  logic exp_valid = 0;

  always #5 clk_i = ~clk_i;

  seg_addr_gen uut (.*);

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'd0, o};
    return full[19:0];
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (addr_valid_o !== exp_valid || (exp_valid && addr_o !== exp_addr) || addr_o !== exp_addr) begin
      n_bad++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", tag, addr_o, addr_valid_o, exp_addr, exp_valid);
    end
  endtask

  // called at a negedge; checks at the next negedge
  task automatic step(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic rq, input logic [1:0] sl, input logic [15:0] of,
                      input logic fe, input logic [15:0] ipv, input string tag);
    seg_we_i = we; seg_wsel_i = ws; seg_wdata_i = wd;
    req_i = rq; seg_sel_i = sl; offset_i = of; fetch_i = fe; ip_i = ipv;
    exp_valid = rq | fe;
    if (fe) exp_addr = pa(model[1], ipv);
    else if (rq) exp_addr = pa(model[sl], of);
    if (we) model[ws] = wd;
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    model[0] = 0; model[1] = 16'hFFFF; model[2] = 0; model[3] = 0;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset");
    // R1 R3 R6: reset code segment FFFF with ip 0010 wraps to 00000
    step(0, 0, 0, 0, 0, 0, 1, 16'h0010, "R3 R6 wrap via reset code seg");
    step(0, 0, 0, 0, 0, 0, 1, 16'h0000, "R1 code seg reset FFFF0");
    // R8 idle hold
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle hold");
    // R2 R4 data segment 2000:0050
    step(1, 2'd3, 16'h2000, 0, 0, 0, 0, 0, "R4 write data seg");
    step(0, 0, 0, 1, 2'd3, 16'h0050, 0, 0, "R2 R4 2000:0050");
    // R9 disabled write
    step(0, 2'd3, 16'h7777, 0, 0, 0, 0, 0, "R9 we low");
    step(0, 0, 0, 1, 2'd3, 16'h0000, 0, 0, "R9 data seg unchanged");
    // R5 same-cycle write and request
    step(1, 2'd2, 16'h1234, 1, 2'd2, 16'h0001, 0, 0, "R5 old value used");
    step(0, 0, 0, 1, 2'd2, 16'h0001, 0, 0, "R5 new value visible");
    // R4 each select
    step(1, 2'd0, 16'hA000, 0, 0, 0, 0, 0, "R4 write extra");
    step(0, 0, 0, 1, 2'd0, 16'h0003, 0, 0, "R4 extra seg");
    step(1, 2'd1, 16'h0100, 0, 0, 0, 0, 0, "R4 write code");
    step(0, 0, 0, 1, 2'd1, 16'h0002, 0, 0, "R4 code seg");
    // R6 fetch beats request
    step(0, 0, 0, 1, 2'd3, 16'hFFFF, 1, 16'h0020, "R6 fetch priority");
    // R3 wrap on generic path
    step(1, 2'd3, 16'hF800, 0, 0, 0, 0, 0, "R3 write");
    step(0, 0, 0, 1, 2'd3, 16'hFFFF, 0, 0, "R3 wrap data");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 2'($urandom), 16'($urandom),
           ($urandom % 3) != 0, 2'($urandom), 16'($urandom),
           ($urandom % 5) == 0, 16'($urandom), "R2 R7 R8 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule